// File: doc/BRIEF.md
# DSD Stuck-Level Detector and Output Mute

This block sits in the one-bit audio path of a two-channel DSD playback chain. It watches the left and right bit streams, counts how long each channel has held the same value, and reports a channel as stuck at full scale once that run reaches a set length. A run of ones and a run of zeros both count. Each channel has its own read-only flag.

When muting is enabled and either flag is set, both outputs are replaced by an alternating idle pattern, so no DC level reaches the converter. Two release policies are available. In automatic mode the mute lifts by itself as soon as neither channel is stuck. In hold mode the mute stays on until a one-cycle release request arrives, and that request is ignored in automatic mode. Run counting advances only on cycles where the sample strobe is high.

Top module: `dsd_stuck_mute`

## Requirements
- R1: A channel's flag rises in the clock cycle after the 2048th consecutive strobed sample of equal value (all ones or all zeros). It is still low after 2047 such samples.
- R2: The run count saturates. The flag stays high while further equal samples arrive, and it drops in the cycle after one strobed sample that differs from the previous sample on that channel.
- R3: After reset, both flags are 0, the mute is off, and each output equals its input.
- R4: When muteEn=1, the mute turns on one clock after either flag is high. When muteEn=0 (the reset value), the mute never turns on and the outputs follow the inputs, even while a flag is high.
- R5: With muteEn=1 and holdMode=0 (automatic return, the reset value), the mute turns off one clock after both flags are low.
- R6: With muteEn=1 and holdMode=1, the mute stays on after both flags fall, for as long as no release request arrives.
- R7: A one-cycle relWrite=1 with muteEn=1 and holdMode=1 turns a held mute off at the next clock.
- R8: If a flag is still high when a held mute is released, the mute turns on again on the following clock.
- R9: relWrite has no effect when holdMode=0. A mute caused by a present flag stays on.
- R10: Input bits presented with sampleStb=0 do not change the run counts or the flags.
- R11: While muted, both outputs carry the same pattern. It is 1 in the first cycle after mute entry and inverts on every clock after that, whatever the input bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleStb | input | 1 | High on cycles that carry a valid DSD sample |
| dsdInL | input | 1 | Left DSD input bit |
| dsdInR | input | 1 | Right DSD input bit |
| muteEn | input | 1 | 1 enables stuck-level muting |
| holdMode | input | 1 | 0 = automatic return, 1 = hold until release |
| relWrite | input | 1 | One-cycle release request, used only in hold mode |
| dsdOutL | output | 1 | Left DSD output, idle pattern while muted |
| dsdOutR | output | 1 | Right DSD output, idle pattern while muted |
| fullFlagL | output | 1 | Left channel stuck at full scale |
| fullFlagR | output | 1 | Right channel stuck at full scale |

## Verification
A run counter that is off by one would move the flag edge by one sample, so the flag is checked after exactly 2047 samples and again after 2048. A counter that wraps instead of saturating would drop the flag during a long run. A mute state register that tracks the wrong condition shows up within one or two clocks: the outputs either keep following a constant input or stop following a toggling one. The idle pattern is detected by watching the outputs change over two clocks while the input is held constant.

// File: rtl/dsd_mute_pkg.sv
package dsd_mute_pkg;
  localparam int NUM_CH = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic muteOn;      // replace outputs by idle pattern
    logic restartIdle; // first cycle of a new mute: idle starts at 1
  } muteStrobe_t;
endpackage

// File: rtl/dsd_run_datapath.sv
module dsd_run_datapath
  import dsd_mute_pkg::*;
#(
  parameter int RUN_LEN = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [NUM_CH-1:0] dsdIn,
  input  muteStrobe_t       strobes,
  output logic [NUM_CH-1:0] dsdOut,
  output logic [NUM_CH-1:0] fullFlag
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic idleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    idleBit <= 1'b0;
    else if (strobes.restartIdle) idleBit <= 1'b1;
    else                          idleBit <= ~idleBit;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] runCnt;
    logic             prevBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt  <= '0;
        prevBit <= 1'b0;
      end else if (sampleStb) begin
        prevBit <= dsdIn[ch];
        if (runCnt != '0 && dsdIn[ch] == prevBit) begin
          if (runCnt != CNT_MAX) runCnt <= runCnt + 1'b1;
        end else begin
          runCnt <= CNT_W'(1);
        end
      end
    end

    assign fullFlag[ch] = (runCnt == CNT_MAX);
    assign dsdOut[ch]   = strobes.muteOn ? idleBit : dsdIn[ch];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      runCnt <= CNT_MAX); // R2
    AST_FLAG_NO_STB: assert property (@(posedge clk) disable iff (!rstN)
      !sampleStb |=> $stable(fullFlag[ch])); // R10
    AST_FLAG_SAT: assert property (@(posedge clk) disable iff (!rstN)
      (sampleStb && fullFlag[ch] && dsdIn[ch] == prevBit) |=> fullFlag[ch]); // R2
  end

  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.muteOn && !strobes.restartIdle) |=> (idleBit != $past(idleBit)) || strobes.restartIdle); // R11
endmodule

// File: rtl/dsd_mute_ctrl.sv
module dsd_mute_ctrl
  import dsd_mute_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] fullFlag,
  input  logic              muteEn,
  input  logic              holdMode,
  input  logic              relWrite,
  output muteStrobe_t       strobes
);
  logic muted;
  logic anyFlag;
  logic releaseNow;
  logic enterNow;

  assign anyFlag    = |fullFlag;
  assign releaseNow = holdMode ? relWrite : !anyFlag;
  assign enterNow   = muteEn && !muted && anyFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 muted <= 1'b0;
    else if (!muteEn)          muted <= 1'b0;
    else if (muted)            muted <= !releaseNow;
    else if (anyFlag)          muted <= 1'b1;
  end

  logic enteredLast;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enteredLast <= 1'b0;
    else       enteredLast <= enterNow;
  end

  assign strobes.muteOn      = muted;
  assign strobes.restartIdle = enterNow;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !muteEn |=> !muted); // R4
  AST_ENTER_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn && anyFlag && !(holdMode && relWrite)) |=> muted); // R4
  AST_AUTO_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn && !holdMode && muted && !anyFlag) |=> !muted); // R5
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn && holdMode && muted && !relWrite) |=> muted); // R6
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn && holdMode && muted && relWrite) |=> !muted); // R7
  AST_MUTE_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    enteredLast |-> muted || !$past(muteEn)); // R11
endmodule

// File: rtl/dsd_stuck_mute.sv
module dsd_stuck_mute
  import dsd_mute_pkg::*;
#(
  parameter int RUN_LEN = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleStb,
  input  logic dsdInL,
  input  logic dsdInR,
  input  logic muteEn,
  input  logic holdMode,
  input  logic relWrite,
  output logic dsdOutL,
  output logic dsdOutR,
  output logic fullFlagL,
  output logic fullFlagR
);
  muteStrobe_t       strobes;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] outBits;

  dsd_run_datapath #(.RUN_LEN(RUN_LEN)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .dsdIn     ({dsdInR, dsdInL}),
    .strobes   (strobes),
    .dsdOut    (outBits),
    .fullFlag  (flags)
  );

  dsd_mute_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fullFlag (flags),
    .muteEn   (muteEn),
    .holdMode (holdMode),
    .relWrite (relWrite),
    .strobes  (strobes)
  );

  assign dsdOutL   = outBits[0];
  assign dsdOutR   = outBits[1];
  assign fullFlagL = flags[0];
  assign fullFlagR = flags[1];

  AST_MUTE_SAME_OUT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.muteOn |-> dsdOutL == dsdOutR); // R11
endmodule

// File: tb/test_dsd_stuck_mute.sv
module test_dsd_stuck_mute;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0, dsdInL = 1'b0, dsdInR = 1'b0;
  logic muteEn = 1'b0, holdMode = 1'b0, relWrite = 1'b0;
  logic dsdOutL, dsdOutR, fullFlagL, fullFlagR;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsd_stuck_mute i_dsd_stuck_mute (.*);

  // pattern codes: 0 = const 0, 1 = const 1, 2 = alternate each sample
  typedef struct packed {
    logic [1:0]  patL;
    logic [1:0]  patR;
    logic [11:0] n;
    logic        en;
    logic        hold;
    logic        fL;
    logic        fR;
    logic        mu;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TABLE [NV] = '{
    '{2'd1, 2'd2, 12'd2047, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 not yet
    '{2'd1, 2'd2, 12'd1,    1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R1 R4 at 2048
    '{2'd2, 2'd2, 12'd1,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R2
    '{2'd2, 2'd0, 12'd2048, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 zeros
    '{2'd2, 2'd0, 12'd100,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 saturate
    '{2'd2, 2'd2, 12'd1,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{2'd1, 2'd2, 12'd2048, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 disabled
    '{2'd1, 2'd2, 12'd1,    1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 hold
    '{2'd2, 2'd2, 12'd1,    1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R6
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic applySamples(input logic [1:0] pL, input logic [1:0] pR, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dsdInL = (pL == 2'd2) ? ~dsdInL : pL[0];
      dsdInR = (pR == 2'd2) ? ~dsdInR : pR[0];
      sampleStb = 1'b1;
    end
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  // R11: muted means both outputs equal and toggling while inputs are held
  task automatic checkMuted(input string req, input logic expMute);
    logic a, b, ar;
    repeat (3) @(negedge clk);
    a = dsdOutL; ar = dsdOutR;
    @(negedge clk);
    b = dsdOutL;
    if (expMute) begin
      check(req, (a != b) && (a == ar), 1'b1, "mute idle pattern (R11)");
    end else begin
      check(req, (a == dsdInL) && (b == dsdInL) && (ar == dsdInR), 1'b1, "outputs follow inputs");
    end
  endtask

  task automatic pulseRelease();
    @(negedge clk);
    relWrite = 1'b1;
    @(negedge clk);
    relWrite = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3", fullFlagL, 1'b0, "flagL after reset");
    check("R3", fullFlagR, 1'b0, "flagR after reset");
    rstN = 1'b1;
    dsdInL = 1'b1; dsdInR = 1'b0;
    checkMuted("R3", 1'b0);

    for (int v = 0; v < NV; v++) begin
      muteEn = TABLE[v].en;
      holdMode = TABLE[v].hold;
      applySamples(TABLE[v].patL, TABLE[v].patR, int'(TABLE[v].n));
      check("R1/R2", fullFlagL, TABLE[v].fL, $sformatf("vec %0d flagL", v));
      check("R1/R2", fullFlagR, TABLE[v].fR, $sformatf("vec %0d flagR", v));
      checkMuted($sformatf("R4/R5/R6 vec %0d", v), TABLE[v].mu);
    end

    // R7: release held mute (flags low)
    pulseRelease();
    checkMuted("R7", 1'b0);

    // R8: release while flag still present -> re-enters
    applySamples(2'd1, 2'd2, 2048);
    check("R8", fullFlagL, 1'b1, "flagL before release");
    checkMuted("R8", 1'b1);
    pulseRelease();
    checkMuted("R8", 1'b1);

    // R9: release ignored in automatic mode
    holdMode = 1'b0;
    pulseRelease();
    checkMuted("R9", 1'b1);

    // R10: unstrobed bits do not affect the run
    @(negedge clk);
    dsdInL = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", fullFlagL, 1'b1, "flagL with unstrobed change");
    applySamples(2'd0, 2'd2, 1);
    check("R2", fullFlagL, 1'b0, "flagL after differing sample");
    checkMuted("R5", 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule